// File: doc/BRIEF.md
# Swizzled Buffer Address Generator

This block turns the address operands of one lane's buffer memory access into a 32-bit byte offset inside the buffer. It takes the per-instruction enables for the vector index and the vector offset, an immediate offset, up to two vector operand words, the lane number, and a handful of descriptor fields: stride, the swizzle switch, the lane-add switch, and two 2-bit codes that set the swizzle group size and the element size. Adding a base address, checking bounds, formatting data and doing the access itself belong to the blocks downstream.

Two layouts are supported. In the linear layout each record starts `stride` bytes after the one before it. In the swizzled layout consecutive indices are grouped, and within a group the elements of the records sit side by side, so lanes that read the same field of neighbouring records touch adjacent memory. Every split point is a power of two, so the block uses only shifts and masks, and the one multiply is by the stride. A request is accepted with a valid/ready handshake, and its result is held in a single output register until the consumer takes it.

Top module: `swz_buf_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request accepted on a clock edge (`req_valid` and `req_ready` both high) shows its result on `rsp_offset` with `rsp_valid` high after that edge. `req_ready` is low exactly while a response is waiting with `rsp_ready` low.
- R3: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_offset` does not change.
- R4: With both `idx_en` and `off_en` set, `opnd0` is the vector index and `opnd1` is the vector offset. With only one of them set, `opnd0` supplies that operand. `opnd1` has no effect unless both are set.
- R5: The index is the sum of `opnd0`, when the index is enabled, and the 6-bit `lane_id`, when `tid_en` is set. Otherwise each term is zero.
- R6: The offset is `imm_off`, zero-extended, plus the vector offset when `off_en` is set.
- R7: With `swz_en` = 0, the result is index × stride + offset.
- R8: An index-stride code k gives a group size of 8 << k (8, 16, 32 or 64 indices). An element-size code k gives 2 << k bytes (2, 4, 8 or 16).
- R9: With `swz_en` = 1, let G be the group size and E the element size. The result is ((index / G) × stride + (offset / E) × E) × G + (index mod G) × E + (offset mod E).
- R10: With a stride of 1 in the linear layout, the result is the element index plus the offset (the formatted-buffer case).
- R11: All sums and products wrap modulo 2^32, with no saturation and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| idx_en | input | 1 | Use a vector index operand |
| off_en | input | 1 | Use a vector offset operand |
| imm_off | input | 12 | Immediate byte offset from the instruction |
| opnd0 | input | 32 | First vector operand word |
| opnd1 | input | 32 | Second vector operand word |
| lane_id | input | 6 | Lane number of the request |
| stride | input | 14 | Record stride in bytes |
| swz_en | input | 1 | Select the swizzled layout |
| tid_en | input | 1 | Add the lane number to the index |
| idx_stride_code | input | 2 | Swizzle group size code |
| elem_size_code | input | 2 | Swizzled element size code |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_offset | output | 32 | Computed byte offset |

## Verification
The assertions assume the consumer obeys the handshake, and they assume the request fields are stable only in the cycle the request is accepted. They check arithmetic only on narrow slices: an immediate-only linear request, a stride-1 linear index, and the lowest bit of a swizzled result with 2-byte elements. Full results are left to the bench's model. The stimulus presents each request for exactly one accepted cycle and stalls the consumer on some vectors. It draws the 2-bit codes, both layouts and all four enable pairs uniformly, and pushes operands to extreme values so that wrap-around occurs.

// File: rtl/bufaddr_pkg.sv
// Package: shared widths, the operand pair type, and the code decoders
// for the buffer address generator.
// Assumes: both size codes are unsigned and use the power-of-two encoding.
package bufaddr_pkg;

    localparam int ADDR_W      = 32;
    localparam int STRIDE_W    = 14;
    localparam int LANE_W      = 6;
    localparam int IMM_W       = 12;
    localparam int CODE_W      = 2;
    localparam int NUM_CODES   = 1 << CODE_W;
    localparam int GRP_BASE_SH = 3;   // group size is 8 << code
    localparam int ELM_BASE_SH = 1;   // element size is 2 << code
    localparam int SH_W        = 4;

    // Index and offset after operand selection
    typedef struct packed {
        logic [ADDR_W-1:0] index;
        logic [ADDR_W-1:0] offset;
    } addr_terms_t;

    // log2 of the swizzle group size for a code
    function automatic logic [SH_W-1:0] grp_shift(input logic [CODE_W-1:0] code);
        return SH_W'(GRP_BASE_SH) + SH_W'(code);
    endfunction

    // log2 of the element size for a code
    function automatic logic [SH_W-1:0] elm_shift(input logic [CODE_W-1:0] code);
        return SH_W'(ELM_BASE_SH) + SH_W'(code);
    endfunction

endpackage

// File: rtl/bufaddr_operand_sel.sv
// Operand selection: builds the index and the offset from the instruction
// enables, the vector words, the lane number and the immediate.
// Assumes: the inputs are steady for the cycle they are sampled; purely combinational.
module bufaddr_operand_sel
    import bufaddr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int LW = LANE_W,
    parameter int IW = IMM_W
) (
    input  logic          idx_en,
    input  logic          off_en,
    input  logic          tid_en,
    input  logic [IW-1:0] imm_off,
    input  logic [AW-1:0] opnd0,
    input  logic [AW-1:0] opnd1,
    input  logic [LW-1:0] lane_id,
    output logic [AW-1:0] index,
    output logic [AW-1:0] offset
);

    logic [AW-1:0] vec_index;
    logic [AW-1:0] vec_offset;
    logic [AW-1:0] lane_term;

    // Route the vector words: word 1 carries the offset only when both are enabled
    always_comb begin
        vec_index  = idx_en ? opnd0 : '0;
        vec_offset = '0;
        if (off_en) begin
            vec_offset = idx_en ? opnd1 : opnd0;
        end
    end

    // Lane number enters the index only when the descriptor asks for it
    always_comb begin
        lane_term = tid_en ? AW'(lane_id) : '0;
    end

    // Sum the terms, wrapping at the address width
    always_comb begin
        index  = vec_index + lane_term;
        offset = AW'(imm_off) + vec_offset;
    end

endmodule

// File: rtl/bufaddr_linear.sv
// Linear layout: record index times stride plus byte offset.
// Assumes: wrap-around at the address width is intended; combinational.
module bufaddr_linear
    import bufaddr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = STRIDE_W
) (
    input  logic [AW-1:0] index,
    input  logic [AW-1:0] offset,
    input  logic [SW-1:0] stride,
    output logic [AW-1:0] result
);

    logic [AW-1:0] scaled;

    // Product truncated to the address width
    always_comb begin
        scaled = index * AW'(stride);
    end

    // Add the byte offset
    always_comb begin
        result = scaled + offset;
    end

endmodule

// File: rtl/bufaddr_swizzle.sv
// Swizzled layout: splits the index by the group size and the offset by the
// element size, then interleaves elements inside each group of records.
// Every divide and remainder is a shift or a mask; one candidate per code
// value is built in a generate loop and the code picks one.
// Assumes: codes cover 0..NUM_CODES-1; combinational.
module bufaddr_swizzle
    import bufaddr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = STRIDE_W,
    parameter int CW = CODE_W
) (
    input  logic [AW-1:0] index,
    input  logic [AW-1:0] offset,
    input  logic [SW-1:0] stride,
    input  logic [CW-1:0] grp_code,
    input  logic [CW-1:0] elm_code,
    output logic [AW-1:0] result
);

    localparam int NC = 1 << CW;

    logic [AW-1:0] iq_c [NC];
    logic [AW-1:0] ir_c [NC];
    logic [AW-1:0] oq_c [NC];   // offset quotient already scaled back by element size
    logic [AW-1:0] or_c [NC];

    // One quotient/remainder pair per code value
    for (genvar g = 0; g < NC; g++) begin : g_split
        localparam int GSH = GRP_BASE_SH + g;
        localparam int ESH = ELM_BASE_SH + g;
        localparam logic [AW-1:0] GMASK = AW'((64'd1 << GSH) - 64'd1);
        localparam logic [AW-1:0] EMASK = AW'((64'd1 << ESH) - 64'd1);

        // Index split at the group boundary
        always_comb begin
            iq_c[g] = index >> GSH;
            ir_c[g] = index & GMASK;
        end

        // Offset split at the element boundary
        always_comb begin
            oq_c[g] = offset & ~EMASK;
            or_c[g] = offset & EMASK;
        end
    end

    logic [AW-1:0]   iq, ir, oq_scaled, orem;
    logic [SH_W-1:0] gsh, esh;
    logic [AW-1:0]   major, minor;

    // Pick the candidates named by the two codes
    always_comb begin
        iq        = iq_c[grp_code];
        ir        = ir_c[grp_code];
        oq_scaled = oq_c[elm_code];
        orem      = or_c[elm_code];
        gsh       = grp_shift(grp_code);
        esh       = elm_shift(elm_code);
    end

    // Group part: record column times stride plus element column, scaled by group size
    always_comb begin
        major = ((iq * AW'(stride)) + oq_scaled) << gsh;
    end

    // In-group part: lane slot times element size plus byte within the element
    always_comb begin
        minor = (ir << esh) + orem;
    end

    // Final sum, wrapping at the address width
    always_comb begin
        result = major + minor;
    end

endmodule

// File: rtl/swz_buf_addr_gen.sv
// Top: valid/ready front, operand selection, both layout datapaths chosen by
// the descriptor, and one output register that holds the result until taken.
// Assumes: request fields are valid in the cycle req_valid is high.
module swz_buf_addr_gen
    import bufaddr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = STRIDE_W,
    parameter int LW = LANE_W,
    parameter int IW = IMM_W,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          idx_en,
    input  logic          off_en,
    input  logic [IW-1:0] imm_off,
    input  logic [AW-1:0] opnd0,
    input  logic [AW-1:0] opnd1,
    input  logic [LW-1:0] lane_id,
    input  logic [SW-1:0] stride,
    input  logic          swz_en,
    input  logic          tid_en,
    input  logic [CW-1:0] idx_stride_code,
    input  logic [CW-1:0] elem_size_code,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [AW-1:0] rsp_offset
);

    logic [AW-1:0] index, offset;
    logic [AW-1:0] lin_result, swz_result, next_offset;
    logic          accept;

    bufaddr_operand_sel #(.AW(AW), .LW(LW), .IW(IW)) u_sel (
        .idx_en  (idx_en),
        .off_en  (off_en),
        .tid_en  (tid_en),
        .imm_off (imm_off),
        .opnd0   (opnd0),
        .opnd1   (opnd1),
        .lane_id (lane_id),
        .index   (index),
        .offset  (offset)
    );

    bufaddr_linear #(.AW(AW), .SW(SW)) u_lin (
        .index  (index),
        .offset (offset),
        .stride (stride),
        .result (lin_result)
    );

    bufaddr_swizzle #(.AW(AW), .SW(SW), .CW(CW)) u_swz (
        .index    (index),
        .offset   (offset),
        .stride   (stride),
        .grp_code (idx_stride_code),
        .elm_code (elem_size_code),
        .result   (swz_result)
    );

    // Layout select and handshake decode
    always_comb begin
        next_offset = swz_en ? swz_result : lin_result;
        req_ready   = !rsp_valid || rsp_ready;
        accept      = req_valid && req_ready;
    end

    // Output slot occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
        end else if (req_ready) begin
            rsp_valid <= req_valid;
        end
    end

    // Output payload, loaded only on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_offset <= '0;
        end else if (accept) begin
            rsp_offset <= next_offset;
        end
    end

endmodule

// Checker: handshake and arithmetic-slice properties for the generator.
// Assumes: consumer follows valid/ready; inputs sampled only on acceptance.
module swz_buf_addr_gen_chk #(
    parameter int AW = 32,
    parameter int SW = 14,
    parameter int IW = 12,
    parameter int CW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          idx_en,
    input logic          off_en,
    input logic          tid_en,
    input logic          swz_en,
    input logic [IW-1:0] imm_off,
    input logic [AW-1:0] opnd0,
    input logic [AW-1:0] opnd1,
    input logic [SW-1:0] stride,
    input logic [CW-1:0] elem_size_code,
    input logic          rsp_valid,
    input logic          rsp_ready,
    input logic [AW-1:0] rsp_offset
);

    logic acc;
    always_comb acc = req_valid && req_ready;

    assert_resp_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);

    assert_backpressure_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |-> !req_ready);

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_offset)));

    assert_imm_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !idx_en && !off_en && !tid_en && !swz_en) |=> (rsp_offset == AW'($past(imm_off))));

    assert_unit_stride_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !swz_en && stride == SW'(1) && idx_en && !off_en && !tid_en)
        |=> (rsp_offset == $past(opnd0 + AW'(imm_off))));

    assert_swz_lsb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && swz_en && elem_size_code == '0)
        |=> (rsp_offset[0] == $past(imm_off[0] ^ (off_en & (idx_en ? opnd1[0] : opnd0[0])))));

endmodule

bind swz_buf_addr_gen swz_buf_addr_gen_chk #(.AW(AW), .SW(SW), .IW(IW), .CW(CW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .idx_en         (idx_en),
    .off_en         (off_en),
    .tid_en         (tid_en),
    .swz_en         (swz_en),
    .imm_off        (imm_off),
    .opnd0          (opnd0),
    .opnd1          (opnd1),
    .stride         (stride),
    .elem_size_code (elem_size_code),
    .rsp_valid      (rsp_valid),
    .rsp_ready      (rsp_ready),
    .rsp_offset     (rsp_offset)
);

// File: tb/swz_buf_addr_gen_test.sv
// Bench: directed corners plus seeded random vectors, each compared with a
// behavioural model written from the requirements.
module swz_buf_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        idx_en = 1'b0, off_en = 1'b0, swz_en = 1'b0, tid_en = 1'b0;
    logic [11:0] imm_off = '0;
    logic [31:0] opnd0 = '0, opnd1 = '0;
    logic [5:0]  lane_id = '0;
    logic [13:0] stride = '0;
    logic [1:0]  isc = '0, esc = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_offset;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    swz_buf_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .idx_en(idx_en), .off_en(off_en), .imm_off(imm_off), .opnd0(opnd0),
        .opnd1(opnd1), .lane_id(lane_id), .stride(stride), .swz_en(swz_en),
        .tid_en(tid_en), .idx_stride_code(isc), .elem_size_code(esc),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_offset(rsp_offset)
    );

    // Reference model from R4..R11
    function automatic logic [31:0] model(
        input bit ie, input bit oe, input bit te, input bit se,
        input logic [11:0] imm, input logic [31:0] w0, input logic [31:0] w1,
        input logic [5:0] lane, input logic [13:0] st, input logic [1:0] ic, input logic [1:0] ec);
        logic [31:0] idx, off, g, e;
        idx = (ie ? w0 : 32'd0) + (te ? {26'd0, lane} : 32'd0);
        off = {20'd0, imm} + (oe ? (ie ? w1 : w0) : 32'd0);
        if (!se) return idx * {18'd0, st} + off;
        g = 32'd8 << ic;
        e = 32'd2 << ec;
        return ((idx / g) * {18'd0, st} + (off / e) * e) * g + (idx % g) * e + (off % e);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Apply one request, optionally stall the consumer, check the result
    task automatic apply(input string tag, input bit ie, input bit oe, input bit te, input bit se,
        input logic [11:0] imm, input logic [31:0] w0, input logic [31:0] w1,
        input logic [5:0] lane, input logic [13:0] st, input logic [1:0] ic, input logic [1:0] ec,
        input bit stall);
        logic [31:0] exp;
        exp = model(ie, oe, te, se, imm, w0, w1, lane, st, ic, ec);
        idx_en = ie; off_en = oe; tid_en = te; swz_en = se; imm_off = imm;
        opnd0 = w0; opnd1 = w1; lane_id = lane; stride = st; isc = ic; esc = ec;
        rsp_ready = !stall;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        opnd0 = ~w0; opnd1 = ~w1;   // later input changes must not leak into the result
        check({tag, " R2 valid"}, {31'd0, rsp_valid}, 32'd1);
        check(tag, rsp_offset, exp);
        if (stall) begin
            for (int k = 0; k < 2; k++) begin
                @(negedge clk);
                check("R3 hold valid", {31'd0, rsp_valid}, 32'd1);
                check("R3 hold data", rsp_offset, exp);
                check("R2 ready low", {31'd0, req_ready}, 32'd0);
            end
            rsp_ready = 1'b1;
        end
        @(negedge clk);
        check("R2 drained", {31'd0, rsp_valid}, 32'd0);
    endtask

    // Watchdog
    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {31'd0, rsp_valid}, 32'd0);
        check("R1 ready after reset", {31'd0, req_ready}, 32'd1);

        // Directed corners
        apply("R6 imm only",          0,0,0,0, 12'hABC, 32'h0, 32'h0, 6'd0, 14'd16, 0,0, 0);
        apply("R7 linear index",      1,0,0,0, 12'd4, 32'd10, 32'hFFFF_FFFF, 6'd0, 14'd12, 0,0, 0);
        apply("R4 offset only opnd0", 0,1,0,0, 12'd1, 32'd100, 32'd777, 6'd0, 14'd8, 0,0, 0);
        apply("R4 both words",        1,1,0,0, 12'd0, 32'd3, 32'd5, 6'd0, 14'd20, 0,0, 1);
        apply("R5 lane added",        1,0,1,0, 12'd0, 32'd2, 32'd0, 6'd63, 14'd4, 0,0, 0);
        apply("R5 lane alone",        0,0,1,0, 12'd0, 32'd9, 32'd9, 6'd17, 14'd16, 0,0, 0);
        apply("R10 unit stride",      1,0,0,0, 12'd7, 32'd1000, 32'd0, 6'd0, 14'd1, 0,0, 0);
        apply("R11 wrap",             1,1,0,0, 12'hFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd0, 14'h3FFF, 0,0, 0);
        apply("R9 swz min codes",     1,1,0,1, 12'd0, 32'd9, 32'd3, 6'd0, 14'd16, 0,0, 0);
        apply("R8 R9 swz max codes",  1,1,1,1, 12'd5, 32'd130, 32'd37, 6'd1, 14'd64, 3,3, 1);
        for (int ic = 0; ic < 4; ic++) begin
            for (int ec = 0; ec < 4; ec++) begin
                apply("R8 code sweep", 1,1,0,1, 12'd3, 32'd77, 32'd29, 6'd0, 14'd48, 2'(ic), 2'(ec), 0);
            end
        end
        apply("R11 swz wrap",         1,1,1,1, 12'hFFF, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 6'd63, 14'h3FFF, 3,1, 0);

        // Seeded random vectors over every enable pair and both layouts
        for (int v = 0; v < 3000; v++) begin
            logic [31:0] w0, w1;
            w0 = $urandom();
            w1 = $urandom();
            if (v % 7 == 0) w0 = 32'hFFFF_FFFF - 32'($urandom_range(0, 15));
            if (v % 5 == 0) w0 = 32'($urandom_range(0, 200));
            apply("R4 R5 R7 R9 random", 1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()),
                  12'($urandom()), w0, w1, 6'($urandom()), 14'($urandom()),
                  2'($urandom()), 2'($urandom()), (v % 9 == 0));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule